// File: doc/BRIEF.md
# Sample Channel Fetch and End-of-Sample Interrupt

This block is the fetch side of a delta-modulation sample channel. Software programs a start code, a length code and a control byte, then turns the channel on. While bytes remain and the one-byte sample buffer is empty, the block asks an external DMA arbiter for a read at its current fetch address. It moves to the next address and counts the remaining bytes down as each fetch ends.

The fetched byte is not placed in the buffer when the DMA finishes. It passes through a short pipeline and lands in the buffer a fixed number of cycles later (two by default). The end-of-sample interrupt is raised on that same delayed load. This delay sets the outcome of three races: a refill against a consume, an interrupt-enable clear against the interrupt, and a channel disable against the interrupt.

A strobe marks fetches whose low five address bits select a side-effect register, whatever the upper address bits are. The output shift unit, the rate timer and the arbiter sit outside this block.

Top module: `smp_fetch_unit`

## Requirements
- R1: After reset, `dma_req`, `buf_full`, `irq` and `bytes_pending` are low and `dma_addr` is 16'hC000.
- R2: Register selects on `reg_sel`:
  - 0 is control, with bit 7 as interrupt enable and bit 6 as loop.
  - 1 is the start code; the start address is 16'hC000 + code*64.
  - 2 is the length code; the sample is code*16+1 bytes long.
  - 3 is enable/status, with bit 0 as enable.
- R3: `dma_req` is high exactly when bytes remain, the buffer is empty and no fetched byte is still in the load pipeline. `dma_addr` is the address of the next fetch.
- R4: A byte presented with `dma_done` in cycle T becomes `buf_data` at the clock edge that ends cycle T+2. `buf_full` stays low through cycles T+1 and T+2 and is high from T+3.
- R5: When the final byte of a non-looping sample is loaded and interrupt enable is set in that cycle, `irq` rises on the same edge as the buffer load.
- R6: A `buf_take` in the load cycle T+2 is ignored. The buffer ends up full with the new byte and no further fetch is requested.
- R7: A control write that clears interrupt enable during cycle T+1 keeps `irq` low. Such a write also clears a raised `irq`.
- R8: Writing enable=0 clears the remaining count at once. Doing so in cycle T+1 does not cancel the interrupt of a final byte already fetched.
- R9: The fetch address increments by one per byte and goes from 16'hFFFF to 16'h8000.
- R10: With loop set, fetching the final byte reloads the start address and length, and no interrupt is raised.
- R11: Writing enable=1 reloads address and length only when zero bytes remain; otherwise the address and count are kept.
- R12: Any write to select 3 clears `irq`, unless a final-byte load sets it in the same cycle.
- R13: `dma_side_hit` is high in a `dma_done` cycle exactly when `dma_addr[4:0]` equals `SIDE_IDX` (default 5'h16), for any upper address bits.
- R14: Bytes reach `buf_data` in fetch order, each exactly once, and exactly the programmed number of bytes is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| dma_req | output | 1 | Fetch request to the arbiter |
| dma_addr | output | 16 | Address of the next fetch |
| dma_done | input | 1 | Final DMA cycle, data valid |
| dma_data | input | 8 | Fetched byte |
| dma_side_hit | output | 1 | Fetch targets the side-effect register slot |
| buf_take | input | 1 | Output unit consumed the buffer |
| buf_full | output | 1 | Sample buffer holds a byte |
| buf_data | output | 8 | Sample buffer contents |
| bytes_pending | output | 1 | Status: bytes remain |
| irq | output | 1 | End-of-sample interrupt flag |

## Verification
Directed sequences place one action in each cycle of the gap after a fetch: an enable clear, a channel disable and a consume. Each result pins down the cycle on which the load and the interrupt take effect. A one-byte sample separates the interrupt path from the loop path. A 65-byte run that starts near the top of memory exposes the wrap and shows whether side-hit decoding ignores the upper address bits. Random runs with random arbiter latency, random consume timing and random start and length codes compare the delivered byte stream against the fetched one, which catches lost, doubled or extra fetches.

// File: rtl/smpf_pkg.sv
package smpf_pkg;
  localparam int SMPF_AW = 16;
  localparam int SMPF_DW = 8;
  localparam int SMPF_LW = 12;
  localparam logic [SMPF_AW-1:0] SMPF_ORG = 16'hC000;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_STAT = 2'd3
  } smpf_sel_e;

  function automatic logic [SMPF_AW-1:0] base_of(input logic [7:0] code);
    return SMPF_ORG + {2'b00, code, 6'b000000};
  endfunction

  function automatic logic [SMPF_LW-1:0] len_of(input logic [7:0] code);
    return {code, 4'b0000} + SMPF_LW'(1);
  endfunction
endpackage

// File: rtl/smpf_cursor.sv
module smpf_cursor
  import smpf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               reload,
  input  logic               step,
  input  logic               loop_mode,
  input  logic [SMPF_AW-1:0] base_addr,
  input  logic [SMPF_LW-1:0] base_len,
  output logic [SMPF_AW-1:0] addr,
  output logic               left_nz,
  output logic               step_last
);
  logic [SMPF_LW-1:0] left, left_n;
  logic [SMPF_AW-1:0] addr_n;
  logic               one_left;

  assign one_left = (left == SMPF_LW'(1));
  assign left_nz  = |left;

  always_comb begin
    addr_n    = addr;
    left_n    = left;
    step_last = 1'b0;
    if (clear) begin
      left_n = '0;
    end else if (reload) begin
      addr_n = base_addr;
      left_n = base_len;
    end else if (step && left_nz) begin
      if (one_left && loop_mode) begin
        addr_n = base_addr;
        left_n = base_len;
      end else begin
        addr_n    = {1'b1, addr[SMPF_AW-2:0] + (SMPF_AW-1)'(1)};
        left_n    = left - SMPF_LW'(1);
        step_last = one_left;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= SMPF_ORG;
      left <= '0;
    end else begin
      addr <= addr_n;
      left <= left_n;
    end
  end
endmodule

// File: rtl/smpf_refill.sv
module smpf_refill
  import smpf_pkg::*;
#(
  parameter int LAG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [SMPF_DW-1:0] in_data,
  input  logic               in_last,
  input  logic               take,
  output logic               buf_full,
  output logic [SMPF_DW-1:0] buf_data,
  output logic               load_now,
  output logic               load_last,
  output logic               busy
);
  logic [LAG-1:0]     stg_v, stg_v_n, stg_l, stg_l_n;
  logic [SMPF_DW-1:0] stg_d   [LAG];
  logic [SMPF_DW-1:0] stg_d_n [LAG];
  logic               full_n;
  logic [SMPF_DW-1:0] data_n;

  assign stg_v_n[0] = in_vld;
  assign stg_l_n[0] = in_vld & in_last;
  assign stg_d_n[0] = in_vld ? in_data : stg_d[0];

  for (genvar k = 1; k < LAG; k++) begin : g_stage
    assign stg_v_n[k] = stg_v[k-1];
    assign stg_l_n[k] = stg_l[k-1];
    assign stg_d_n[k] = stg_v[k-1] ? stg_d[k-1] : stg_d[k];
  end

  assign load_now  = stg_v[LAG-1];
  assign load_last = stg_l[LAG-1];
  assign busy      = |stg_v;

  always_comb begin
    full_n = buf_full;
    data_n = buf_data;
    if (load_now) begin
      full_n = 1'b1;
      data_n = stg_d[LAG-1];
    end else if (take) begin
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v    <= '0;
      stg_l    <= '0;
      buf_full <= 1'b0;
      buf_data <= '0;
      for (int k = 0; k < LAG; k++) stg_d[k] <= '0;
    end else begin
      stg_v    <= stg_v_n;
      stg_l    <= stg_l_n;
      buf_full <= full_n;
      buf_data <= data_n;
      for (int k = 0; k < LAG; k++) stg_d[k] <= stg_d_n[k];
    end
  end
endmodule

// File: rtl/smpf_irq.sv
module smpf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq
);
  logic irq_n;

  always_comb begin
    irq_n = irq;
    if (set_evt)      irq_n = 1'b1;
    else if (clr_evt) irq_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_n;
  end
endmodule

// File: rtl/smp_fetch_unit.sv
module smp_fetch_unit
  import smpf_pkg::*;
#(
  parameter int         LOAD_LAG = 2,
  parameter logic [4:0] SIDE_IDX = 5'h16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [7:0]         reg_wdata,
  output logic               dma_req,
  output logic [SMPF_AW-1:0] dma_addr,
  input  logic               dma_done,
  input  logic [SMPF_DW-1:0] dma_data,
  output logic               dma_side_hit,
  input  logic               buf_take,
  output logic               buf_full,
  output logic [SMPF_DW-1:0] buf_data,
  output logic               bytes_pending,
  output logic               irq
);
  logic       ctl_irq_en, ctl_irq_en_n, ctl_loop, ctl_loop_n;
  logic [7:0] base_code, base_code_n, len_code, len_code_n;
  logic       wr_ctrl, wr_base, wr_len, wr_stat;
  logic       left_nz, step_last, ld_now, ld_last, pipe_busy;

  assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
  assign wr_base = reg_we && (reg_sel == SEL_BASE);
  assign wr_len  = reg_we && (reg_sel == SEL_LEN);
  assign wr_stat = reg_we && (reg_sel == SEL_STAT);

  always_comb begin
    ctl_irq_en_n = ctl_irq_en;
    ctl_loop_n   = ctl_loop;
    base_code_n  = base_code;
    len_code_n   = len_code;
    if (wr_ctrl) begin
      ctl_irq_en_n = reg_wdata[7];
      ctl_loop_n   = reg_wdata[6];
    end
    if (wr_base) base_code_n = reg_wdata;
    if (wr_len)  len_code_n  = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_irq_en <= 1'b0;
      ctl_loop   <= 1'b0;
      base_code  <= '0;
      len_code   <= '0;
    end else begin
      ctl_irq_en <= ctl_irq_en_n;
      ctl_loop   <= ctl_loop_n;
      base_code  <= base_code_n;
      len_code   <= len_code_n;
    end
  end

  smpf_cursor u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (wr_stat & ~reg_wdata[0]),
    .reload    (wr_stat & reg_wdata[0] & ~left_nz),
    .step      (dma_done),
    .loop_mode (ctl_loop),
    .base_addr (base_of(base_code)),
    .base_len  (len_of(len_code)),
    .addr      (dma_addr),
    .left_nz   (left_nz),
    .step_last (step_last)
  );

  smpf_refill #(.LAG(LOAD_LAG)) u_refill (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (dma_done),
    .in_data   (dma_data),
    .in_last   (step_last),
    .take      (buf_take),
    .buf_full  (buf_full),
    .buf_data  (buf_data),
    .load_now  (ld_now),
    .load_last (ld_last),
    .busy      (pipe_busy)
  );

  smpf_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (ld_now & ld_last & ctl_irq_en),
    .clr_evt (wr_stat | (wr_ctrl & ~reg_wdata[7])),
    .irq     (irq)
  );

  assign dma_req       = left_nz & ~buf_full & ~pipe_busy;
  assign dma_side_hit  = dma_done & (dma_addr[4:0] == SIDE_IDX);
  assign bytes_pending = left_nz;
endmodule

// File: rtl/smpf_checker.sv
module smpf_checker #(
  parameter int LAG = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dma_req,
  input logic        dma_done,
  input logic        buf_full,
  input logic        irq,
  input logic [15:0] dma_addr,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic        load_now
);
  logic [LAG:0] done_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_hist <= '0;
    else        done_hist <= {done_hist[LAG-1:0], dma_done};
  end

  // R3
  no_req_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !dma_req);

  // R3
  req_drops_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> !dma_req);

  // R4
  load_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> done_hist[LAG]);

  // R5
  irq_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done_hist[LAG]);

  // R9
  addr_upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_addr[15]);

  // R12
  stat_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd3 && !load_now) |=> !irq);
endmodule

bind smp_fetch_unit smpf_checker #(.LAG(LOAD_LAG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dma_req  (dma_req),
  .dma_done (dma_done),
  .buf_full (buf_full),
  .irq      (irq),
  .dma_addr (dma_addr),
  .reg_we   (reg_we),
  .reg_sel  (reg_sel),
  .load_now (ld_now)
);

// File: tb/sim_smp_fetch_unit.sv
`timescale 1ns/1ps
module sim_smp_fetch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic        dma_req;
  logic [15:0] dma_addr;
  logic        dma_done;
  logic [7:0]  dma_data;
  logic        dma_side_hit;
  logic        buf_take;
  logic        buf_full;
  logic [7:0]  buf_data;
  logic        bytes_pending;
  logic        irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  side_seen;
  bit  finished = 1'b0;
  logic [7:0] exp_q [64];

  always #5 clk = ~clk;

  smp_fetch_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_done(dma_done), .dma_data(dma_data), .dma_side_hit(dma_side_hit),
    .buf_take(buf_take), .buf_full(buf_full), .buf_data(buf_data),
    .bytes_pending(bytes_pending), .irq(irq)
  );

  function automatic logic [15:0] exp_base(input logic [7:0] c);
    return 16'hC000 + 16'(c) * 16'd64;
  endfunction

  function automatic int exp_len(input logic [7:0] c);
    return int'(c) * 16 + 1;
  endfunction

  function automatic logic [15:0] exp_next(input logic [15:0] a);
    return (a == 16'hFFFF) ? 16'h8000 : a + 16'd1;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic done_pulse(input logic [7:0] d);
    dma_data = d; dma_done = 1'b1;
    #1 side_seen = dma_side_hit;
    @(negedge clk);
    dma_done = 1'b0;
  endtask

  task automatic take_one();
    buf_take = 1'b1;
    @(negedge clk);
    buf_take = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int hits;
    int addr_bad;
    logic [15:0] ea;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    dma_done = 1'b0; dma_data = '0; buf_take = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", {31'd0, dma_req}, 0);
    chk("R1 full", {31'd0, buf_full}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pending", {31'd0, bytes_pending}, 0);
    chk("R1 addr", {16'd0, dma_addr}, 32'hC000);

    // R2 R11 one-byte sample with interrupt
    wr(0, 8'h80); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h01);
    chk("R3 req", {31'd0, dma_req}, 1);
    chk("R2 addr", {16'd0, dma_addr}, 32'hC000);
    chk("R11 pending", {31'd0, bytes_pending}, 1);
    done_pulse(8'h5A);
    chk("R3 req low after done", {31'd0, dma_req}, 0);
    chk("R4 full T+1", {31'd0, buf_full}, 0);
    chk("R4 pending zero", {31'd0, bytes_pending}, 0);
    @(negedge clk);
    chk("R4 full T+2", {31'd0, buf_full}, 0);
    chk("R5 irq T+2", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R4 full T+3", {31'd0, buf_full}, 1);
    chk("R4 data", {24'd0, buf_data}, 32'h5A);
    chk("R5 irq with load", {31'd0, irq}, 1);

    // R12 status write clears irq
    wr(3, 8'h00);
    chk("R12 irq cleared", {31'd0, irq}, 0);
    take_one();
    chk("R14 take empties", {31'd0, buf_full}, 0);

    // R7 interrupt enable cleared in the gap
    wr(3, 8'h01);
    done_pulse(8'h11);
    wr(0, 8'h00);
    @(negedge clk);
    chk("R7 loaded", {31'd0, buf_full}, 1);
    chk("R7 irq suppressed", {31'd0, irq}, 0);
    take_one();

    // R8 disable in the gap keeps interrupt
    wr(0, 8'h80); wr(3, 8'h01);
    done_pulse(8'h22);
    wr(3, 8'h00);
    @(negedge clk);
    chk("R8 irq kept", {31'd0, irq}, 1);
    chk("R8 data", {24'd0, buf_data}, 32'h22);
    wr(3, 8'h00);
    take_one();

    // R6 consume on load cycle ignored
    wr(2, 8'h01); wr(3, 8'h01);
    done_pulse(8'h33);
    @(negedge clk);
    buf_take = 1'b1;
    @(negedge clk);
    buf_take = 1'b0;
    chk("R6 still full", {31'd0, buf_full}, 1);
    chk("R6 data", {24'd0, buf_data}, 32'h33);
    chk("R6 no extra req", {31'd0, dma_req}, 0);
    take_one();
    chk("R9 next addr", {16'd0, dma_addr}, 32'hC001);
    chk("R3 req resumes", {31'd0, dma_req}, 1);
    wr(3, 8'h00);
    chk("R8 clear pending", {31'd0, bytes_pending}, 0);
    chk("R8 clear req", {31'd0, dma_req}, 0);

    // R10 loop
    wr(0, 8'hC0); wr(2, 8'h00); wr(1, 8'h02); wr(3, 8'h01);
    chk("R2 base code 2", {16'd0, dma_addr}, 32'hC080);
    done_pulse(8'h44);
    chk("R10 reload pending", {31'd0, bytes_pending}, 1);
    chk("R10 reload addr", {16'd0, dma_addr}, 32'hC080);
    @(negedge clk); @(negedge clk);
    chk("R10 no irq", {31'd0, irq}, 0);
    take_one();
    chk("R10 req again", {31'd0, dma_req}, 1);
    wr(3, 8'h00); wr(0, 8'h00);

    // R11 enable with bytes remaining keeps state
    wr(1, 8'h00); wr(2, 8'h01); wr(3, 8'h01);
    done_pulse(8'h55);
    @(negedge clk); @(negedge clk);
    take_one();
    wr(1, 8'h05); wr(3, 8'h01);
    chk("R11 addr kept", {16'd0, dma_addr}, 32'hC001);
    wr(3, 8'h00);

    // R9 R13 wrap run of 65 bytes from FFC0
    wr(1, 8'hFF); wr(2, 8'h04); wr(3, 8'h01);
    hits = 0; addr_bad = 0; ea = exp_base(8'hFF);
    for (int i = 0; i < exp_len(8'h04); i++) begin
      if (i == 64) chk("R9 wrap to 8000", {16'd0, dma_addr}, 32'h8000);
      if (dma_addr !== ea || dma_req !== 1'b1) addr_bad++;
      done_pulse(8'(i));
      if (side_seen) hits++;
      ea = exp_next(ea);
      @(negedge clk); @(negedge clk);
      take_one();
    end
    chk("R9 address sequence errors", addr_bad, 0);
    chk("R13 side hits", hits, 2);
    chk("R14 run length", {31'd0, bytes_pending}, 0);

    // R14 random streams
    for (int run = 0; run < 4; run++) begin
      int wi, ri, total;
      logic [7:0] lc;
      lc = 8'($urandom % 4);
      total = exp_len(lc);
      wr(0, 8'h00); wr(1, 8'($urandom)); wr(2, lc); wr(3, 8'h01);
      wi = 0; ri = 0;
      for (int cyc = 0; cyc < 4000 && ri < total; cyc++) begin
        @(negedge clk);
        if (dma_done) dma_done = 1'b0;
        else if (dma_req && ($urandom % 3 == 0)) begin
          dma_data = 8'($urandom);
          if (wi < 64) exp_q[wi] = dma_data;
          wi++;
          dma_done = 1'b1;
        end
        if (buf_full && ($urandom % 2 == 0)) begin
          chk("R14 byte order", {24'd0, buf_data}, {24'd0, exp_q[ri]});
          ri++;
          buf_take = 1'b1;
        end else begin
          buf_take = 1'b0;
        end
      end
      @(negedge clk);
      buf_take = 1'b0; dma_done = 1'b0;
      repeat (4) @(negedge clk);
      chk("R14 delivered count", ri, total);
      chk("R14 fetched count", wi, total);
    end

    finish_run();
  end
endmodule